// File: doc/BRIEF.md
# Key-Space Sequencer with Byte-Reversed Outer Count

This block sets the order in which a brute-force search core visits candidate keys. A key has three fields: a narrow high word, a wide middle word and a wide low word. The high and middle words together form the inner space, which counts as a plain binary number. The high word is the fast part, and its carry feeds the middle word. Each full pass of the inner space is one work unit. After each work unit the low word takes one step. A mode captured at load time chooses how the low word steps. Compatible order counts it with the byte order reversed, so the byte in the top lane changes fastest. Partition order counts only the bits above the bottom byte as a plain binary number, and the bottom byte keeps its loaded value as a tag that separates cooperating searches.

A host loads a start key and a mode, then issues one step strobe per key it consumes. The block pulses a flag at every work-unit boundary. It pulses a second flag once every group of work units. With the default widths, a group of 256 native units covers one unit of the compatible allocation. When the low word has no further value in the chosen order, the block stops and reports that the space is exhausted.

Top module: `ksq_sequencer`

## Requirements
- R1: A load strobe captures the high, middle and low words and the mode (modeSel 0 = compatible, 1 = partition). It clears exhausted and the group count. From the next cycle the key outputs show the loaded words and keyValid is 1. After reset, all key outputs are 0 and keyValid is 0. A load wins over a step strobe given in the same cycle.
- R2: A step strobe while keyValid is 1 raises {keyMid,keyHi} by one as a binary count in the following cycle. A step strobe while keyValid is 0 changes nothing.
- R3: When keyHi is all ones, a step sets keyHi to 0 and increments keyMid.
- R4: When keyHi and keyMid are both all ones, a step sets both to 0 and advances keyLo. In the same cycle as the new key, unitDone is 1 for exactly one cycle.
- R5: In compatible mode, keyLo advances as a counter whose least significant digit is the byte in bits [LO_W-1:LO_W-BYTE_W]. The carry ripples toward the byte in bits [BYTE_W-1:0].
- R6: In partition mode, bits [LO_W-1:BYTE_W] of keyLo increment as a binary number. Bits [BYTE_W-1:0] keep the loaded tag value.
- R7: groupDone is 1 together with every 2^GRP_LOG2-th unitDone counted since the last load, and at no other time.
- R8: A work-unit wrap with keyLo at its final value ends the sequence. The final value is all ones in compatible mode, or an all-ones counted field in partition mode. That step pulses unitDone, sets exhausted and clears keyValid, and the key outputs keep their value. Later steps are ignored until the next load.
- R9: modeSel has no effect except in a cycle with a load strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| loadStb | input | 1 | Capture start key and mode |
| loadHi | input | HI_W | Start value of high word |
| loadMid | input | MID_W | Start value of middle word |
| loadLo | input | BYTE_W*LO_BYTES | Start value of low word (bottom byte is the tag in partition mode) |
| modeSel | input | 1 | 0 compatible order, 1 partition order; sampled on load |
| stepStb | input | 1 | Advance by one key |
| keyHi | output | HI_W | Current high word |
| keyMid | output | MID_W | Current middle word |
| keyLo | output | BYTE_W*LO_BYTES | Current low word |
| keyValid | output | 1 | Key is loaded and not exhausted |
| unitDone | output | 1 | Pulse on inner-space wrap |
| groupDone | output | 1 | Pulse every 2^GRP_LOG2 work units |
| exhausted | output | 1 | Low word has run past its last value |

## Verification
The bench builds the block with 2-bit high and middle words, 2-bit bytes, three bytes in the low word and groups of four units. A work unit then lasts sixteen steps. A full compatible sweep of the 6-bit low word takes 1024 steps, and a partition sweep of its 4-bit counted field takes 256. Because of these small sizes, the carries across every byte boundary, the group pulse, both exhaustion points and the restart after exhaustion all fall within a short run. A reference model of both orders predicts every key.

// File: rtl/ksq_pkg.sv
`timescale 1ns/1ps
package ksq_pkg;

  typedef enum logic {
    ORDER_COMPAT    = 1'b0,
    ORDER_PARTITION = 1'b1
  } order_e;

  // strobes from control to datapath
  typedef struct packed {
    logic loadKey;
    logic advInner;
    logic advOuter;
  } dp_ctrl_t;

  // status from datapath to control
  typedef struct packed {
    logic innerLast;
    logic outerLast;
  } dp_stat_t;

endpackage

// File: rtl/ksq_outer_step.sv
`timescale 1ns/1ps
module ksq_outer_step
  import ksq_pkg::*;
#(
  parameter int BYTE_W   = 8,
  parameter int LO_BYTES = 4,
  localparam int LO_W    = BYTE_W * LO_BYTES
) (
  input  logic [LO_W-1:0] loCur,
  input  order_e          mode,
  output logic [LO_W-1:0] loNext,
  output logic            loLast
);

  logic [LO_W-1:0] loRev;
  logic [LO_W-1:0] revInc;
  logic [LO_W-1:0] compatNext;
  logic [LO_W-1:0] partNext;
  logic            compatLast;
  logic            partLast;

  // lane g of the reversed view is lane (LO_BYTES-1-g) of the stored word
  for (genvar g = 0; g < LO_BYTES; g++) begin : gSwap
    assign loRev[g*BYTE_W +: BYTE_W]                   = loCur[(LO_BYTES-1-g)*BYTE_W +: BYTE_W];
    assign compatNext[(LO_BYTES-1-g)*BYTE_W +: BYTE_W] = revInc[g*BYTE_W +: BYTE_W];
  end

  assign revInc     = loRev + LO_W'(1);
  assign compatLast = &loCur;

  assign partNext = {loCur[LO_W-1:BYTE_W] + (LO_W-BYTE_W)'(1), loCur[BYTE_W-1:0]};
  assign partLast = &loCur[LO_W-1:BYTE_W];

  always_comb begin
    if (mode == ORDER_PARTITION) begin
      loNext = partNext;
      loLast = partLast;
    end else begin
      loNext = compatNext;
      loLast = compatLast;
    end
  end

endmodule

// File: rtl/ksq_datapath.sv
`timescale 1ns/1ps
module ksq_datapath
  import ksq_pkg::*;
#(
  parameter int HI_W     = 8,
  parameter int MID_W    = 32,
  parameter int BYTE_W   = 8,
  parameter int LO_BYTES = 4,
  localparam int LO_W    = BYTE_W * LO_BYTES,
  localparam int INNER_W = HI_W + MID_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  dp_ctrl_t         ctrl,
  input  logic [HI_W-1:0]  loadHi,
  input  logic [MID_W-1:0] loadMid,
  input  logic [LO_W-1:0]  loadLo,
  input  order_e           loadMode,
  output dp_stat_t         stat,
  output logic [HI_W-1:0]  keyHi,
  output logic [MID_W-1:0] keyMid,
  output logic [LO_W-1:0]  keyLo,
  output order_e           modeQ
);

  logic [INNER_W-1:0] innerQ;
  logic [LO_W-1:0]    loQ;
  logic [LO_W-1:0]    loNext;
  logic               loLast;

  ksq_outer_step #(
    .BYTE_W  (BYTE_W),
    .LO_BYTES(LO_BYTES)
  ) uOuter (
    .loCur (loQ),
    .mode  (modeQ),
    .loNext(loNext),
    .loLast(loLast)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      innerQ <= '0;
      loQ    <= '0;
      modeQ  <= ORDER_COMPAT;
    end else if (ctrl.loadKey) begin
      innerQ <= {loadMid, loadHi};
      loQ    <= loadLo;
      modeQ  <= loadMode;
    end else begin
      if (ctrl.advInner) innerQ <= innerQ + INNER_W'(1);
      if (ctrl.advOuter) loQ    <= loNext;
    end
  end

  assign stat.innerLast = &innerQ;
  assign stat.outerLast = loLast;

  assign keyHi  = innerQ[HI_W-1:0];
  assign keyMid = innerQ[INNER_W-1:HI_W];
  assign keyLo  = loQ;

endmodule

// File: rtl/ksq_control.sv
`timescale 1ns/1ps
module ksq_control
  import ksq_pkg::*;
#(
  parameter int GRP_LOG2 = 8
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     loadStb,
  input  logic     stepStb,
  input  dp_stat_t stat,
  output dp_ctrl_t ctrl,
  output logic     keyValid,
  output logic     unitDone,
  output logic     groupDone,
  output logic     exhausted
);

  logic                loadedQ;
  logic                exhQ;
  logic [GRP_LOG2-1:0] grpQ;
  logic                advance;
  logic                wrapStep;
  logic                finalStep;

  assign keyValid  = loadedQ & ~exhQ;
  assign exhausted = exhQ;

  assign advance   = stepStb & keyValid & ~loadStb;
  assign wrapStep  = advance & stat.innerLast;
  assign finalStep = wrapStep & stat.outerLast;

  always_comb begin
    ctrl.loadKey  = loadStb;
    ctrl.advInner = advance & ~finalStep;
    ctrl.advOuter = wrapStep & ~finalStep;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      loadedQ   <= 1'b0;
      exhQ      <= 1'b0;
      grpQ      <= '0;
      unitDone  <= 1'b0;
      groupDone <= 1'b0;
    end else if (loadStb) begin
      loadedQ   <= 1'b1;
      exhQ      <= 1'b0;
      grpQ      <= '0;
      unitDone  <= 1'b0;
      groupDone <= 1'b0;
    end else begin
      unitDone  <= wrapStep;
      groupDone <= wrapStep & (&grpQ);
      if (wrapStep)  grpQ <= grpQ + GRP_LOG2'(1);
      if (finalStep) exhQ <= 1'b1;
    end
  end

endmodule

// File: rtl/ksq_sequencer.sv
`timescale 1ns/1ps
module ksq_sequencer
  import ksq_pkg::*;
#(
  parameter int HI_W     = 8,
  parameter int MID_W    = 32,
  parameter int BYTE_W   = 8,
  parameter int LO_BYTES = 4,
  parameter int GRP_LOG2 = 8,
  localparam int LO_W    = BYTE_W * LO_BYTES
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             loadStb,
  input  logic [HI_W-1:0]  loadHi,
  input  logic [MID_W-1:0] loadMid,
  input  logic [LO_W-1:0]  loadLo,
  input  logic             modeSel,
  input  logic             stepStb,
  output logic [HI_W-1:0]  keyHi,
  output logic [MID_W-1:0] keyMid,
  output logic [LO_W-1:0]  keyLo,
  output logic             keyValid,
  output logic             unitDone,
  output logic             groupDone,
  output logic             exhausted
);

  dp_ctrl_t dpCtrl;
  dp_stat_t dpStat;
  order_e   dpMode;

  ksq_control #(
    .GRP_LOG2(GRP_LOG2)
  ) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .loadStb  (loadStb),
    .stepStb  (stepStb),
    .stat     (dpStat),
    .ctrl     (dpCtrl),
    .keyValid (keyValid),
    .unitDone (unitDone),
    .groupDone(groupDone),
    .exhausted(exhausted)
  );

  ksq_datapath #(
    .HI_W    (HI_W),
    .MID_W   (MID_W),
    .BYTE_W  (BYTE_W),
    .LO_BYTES(LO_BYTES)
  ) uDp (
    .clk     (clk),
    .rstN    (rstN),
    .ctrl    (dpCtrl),
    .loadHi  (loadHi),
    .loadMid (loadMid),
    .loadLo  (loadLo),
    .loadMode(order_e'(modeSel)),
    .stat    (dpStat),
    .keyHi   (keyHi),
    .keyMid  (keyMid),
    .keyLo   (keyLo),
    .modeQ   (dpMode)
  );

endmodule

// File: rtl/ksq_sequencer_chk.sv
`timescale 1ns/1ps
module ksq_sequencer_chk #(
  parameter int HI_W     = 8,
  parameter int MID_W    = 32,
  parameter int BYTE_W   = 8,
  parameter int LO_BYTES = 4,
  localparam int LO_W    = BYTE_W * LO_BYTES,
  localparam int INNER_W = HI_W + MID_W
) (
  input logic             clk,
  input logic             rstN,
  input logic             loadStb,
  input logic             stepStb,
  input logic [HI_W-1:0]  loadHi,
  input logic [MID_W-1:0] loadMid,
  input logic [LO_W-1:0]  loadLo,
  input logic [HI_W-1:0]  keyHi,
  input logic [MID_W-1:0] keyMid,
  input logic [LO_W-1:0]  keyLo,
  input logic             keyValid,
  input logic             unitDone,
  input logic             groupDone,
  input logic             exhausted,
  input logic             partMode
);

  logic [INNER_W-1:0] innerNow;
  assign innerNow = {keyMid, keyHi};

  assert_load_capture_R1: assert property (@(posedge clk) disable iff (!rstN)
    $past(loadStb) |-> keyValid && !exhausted && keyHi == $past(loadHi)
                       && keyMid == $past(loadMid) && keyLo == $past(loadLo));

  assert_inner_count_R2: assert property (@(posedge clk) disable iff (!rstN)
    $past(stepStb && keyValid && !loadStb && !(&innerNow))
      |-> innerNow == $past(innerNow) + INNER_W'(1) && $stable(keyLo));

  assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    $past(!keyValid && !loadStb) |-> $stable(keyHi) && $stable(keyMid) && $stable(keyLo));

  assert_unit_wrap_R4: assert property (@(posedge clk) disable iff (!rstN)
    unitDone && !exhausted |-> keyHi == '0 && keyMid == '0);

  assert_part_tag_R6: assert property (@(posedge clk) disable iff (!rstN)
    partMode && !$past(loadStb) |-> $stable(keyLo[BYTE_W-1:0]));

  assert_group_with_unit_R7: assert property (@(posedge clk) disable iff (!rstN)
    groupDone |-> unitDone);

  assert_exh_sticky_R8: assert property (@(posedge clk) disable iff (!rstN)
    exhausted && !loadStb |=> exhausted && !keyValid);

  assert_exh_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(exhausted) |-> unitDone && $stable(keyHi) && $stable(keyMid) && $stable(keyLo));

endmodule

bind ksq_sequencer ksq_sequencer_chk #(
  .HI_W    (HI_W),
  .MID_W   (MID_W),
  .BYTE_W  (BYTE_W),
  .LO_BYTES(LO_BYTES)
) uChk (
  .clk      (clk),
  .rstN     (rstN),
  .loadStb  (loadStb),
  .stepStb  (stepStb),
  .loadHi   (loadHi),
  .loadMid  (loadMid),
  .loadLo   (loadLo),
  .keyHi    (keyHi),
  .keyMid   (keyMid),
  .keyLo    (keyLo),
  .keyValid (keyValid),
  .unitDone (unitDone),
  .groupDone(groupDone),
  .exhausted(exhausted),
  .partMode (dpMode == ksq_pkg::ORDER_PARTITION)
);

// File: tb/tb_ksq_sequencer.sv
`timescale 1ns/1ps
module tb_ksq_sequencer;

  localparam int HW = 2;
  localparam int MW = 2;
  localparam int BW = 2;
  localparam int NB = 3;
  localparam int GL = 2;
  localparam int LW = BW * NB;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          loadStb = 1'b0;
  logic [HW-1:0] loadHi = '0;
  logic [MW-1:0] loadMid = '0;
  logic [LW-1:0] loadLo = '0;
  logic          modeSel = 1'b0;
  logic          stepStb = 1'b0;
  logic [HW-1:0] keyHi;
  logic [MW-1:0] keyMid;
  logic [LW-1:0] keyLo;
  logic          keyValid, unitDone, groupDone, exhausted;

  always #2.5 clk = ~clk;

  ksq_sequencer #(
    .HI_W(HW), .MID_W(MW), .BYTE_W(BW), .LO_BYTES(NB), .GRP_LOG2(GL)
  ) dut (
    .clk(clk), .rstN(rstN), .loadStb(loadStb), .loadHi(loadHi), .loadMid(loadMid),
    .loadLo(loadLo), .modeSel(modeSel), .stepStb(stepStb), .keyHi(keyHi),
    .keyMid(keyMid), .keyLo(keyLo), .keyValid(keyValid), .unitDone(unitDone),
    .groupDone(groupDone), .exhausted(exhausted)
  );

  typedef struct {
    logic [HW-1:0] hi;
    logic [MW-1:0] mid;
    logic [LW-1:0] lo;
    logic          valid;
    logic          ud;
    logic          gd;
    logic          exh;
    string         tag;
  } exp_t;

  exp_t q[$];
  int compared = 0;
  int mismatched = 0;
  bit finished = 0;

  // reference model state
  logic [HW-1:0] mHi = '0;
  logic [MW-1:0] mMid = '0;
  logic [LW-1:0] mLo = '0;
  logic          mMode = 1'b0;
  logic          mLoaded = 1'b0;
  logic          mExh = 1'b0;
  logic [GL-1:0] mGrp = '0;
  logic          eUd = 1'b0;
  logic          eGd = 1'b0;

  function automatic logic [LW-1:0] swapBytes(input logic [LW-1:0] v);
    logic [LW-1:0] r;
    r = '0;
    for (int k = 0; k < NB; k++) r[BW*(NB-1-k) +: BW] = v[BW*k +: BW];
    return r;
  endfunction

  task automatic modelStep();
    logic last;
    eUd = 1'b0;
    eGd = 1'b0;
    if (mLoaded && !mExh) begin
      if (mHi == '1 && mMid == '1) begin
        eUd  = 1'b1;
        last = mMode ? (&mLo[LW-1:BW]) : (&mLo);
        if (last) mExh = 1'b1;
        else begin
          mHi  = '0;
          mMid = '0;
          if (mMode) mLo = {mLo[LW-1:BW] + (LW-BW)'(1), mLo[BW-1:0]};
          else       mLo = swapBytes(swapBytes(mLo) + LW'(1));
        end
      end else if (mHi == '1) begin
        mHi  = '0;
        mMid = mMid + MW'(1);
      end else begin
        mHi = mHi + HW'(1);
      end
      if (eUd) begin
        mGrp = mGrp + GL'(1);
        eGd  = (mGrp == '0);
      end
    end
  endtask

  task automatic pushExp(input string tag);
    exp_t e;
    e.hi = mHi; e.mid = mMid; e.lo = mLo;
    e.valid = mLoaded && !mExh; e.ud = eUd; e.gd = eGd; e.exh = mExh;
    e.tag = tag;
    q.push_back(e);
  endtask

  task automatic doLoad(input logic [HW-1:0] h, input logic [MW-1:0] m,
                        input logic [LW-1:0] l, input logic mode,
                        input logic stepToo, input string tag);
    @(negedge clk);
    loadStb = 1'b1; loadHi = h; loadMid = m; loadLo = l; modeSel = mode; stepStb = stepToo;
    mHi = h; mMid = m; mLo = l; mMode = mode; mLoaded = 1'b1; mExh = 1'b0; mGrp = '0;
    eUd = 1'b0; eGd = 1'b0;
    @(posedge clk); #1;
    loadStb = 1'b0; stepStb = 1'b0;
    pushExp(tag);
  endtask

  task automatic doStep(input logic modeNow, input string tag);
    @(negedge clk);
    stepStb = 1'b1; modeSel = modeNow;
    modelStep();
    @(posedge clk); #1;
    stepStb = 1'b0;
    pushExp(tag);
  endtask

  // monitor: compares one expected item per cycle
  always @(negedge clk) begin
    if (q.size() != 0) begin
      exp_t e;
      bit bad;
      e = q.pop_front();
      bad = 0;
      compared++;
      if (keyHi !== e.hi) begin bad = 1; $display("FAIL %s keyHi got %h exp %h", e.tag, keyHi, e.hi); end
      if (keyMid !== e.mid) begin bad = 1; $display("FAIL %s keyMid got %h exp %h", e.tag, keyMid, e.mid); end
      if (keyLo !== e.lo) begin bad = 1; $display("FAIL %s keyLo got %h exp %h", e.tag, keyLo, e.lo); end
      if (keyValid !== e.valid) begin bad = 1; $display("FAIL %s keyValid got %b exp %b", e.tag, keyValid, e.valid); end
      if (unitDone !== e.ud) begin bad = 1; $display("FAIL %s unitDone got %b exp %b", e.tag, unitDone, e.ud); end
      if (groupDone !== e.gd) begin bad = 1; $display("FAIL %s groupDone got %b exp %b", e.tag, groupDone, e.gd); end
      if (exhausted !== e.exh) begin bad = 1; $display("FAIL %s exhausted got %b exp %b", e.tag, exhausted, e.exh); end
      if (bad) mismatched++;
    end
  end

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    compared++;
    mismatched++;
    $display("FAIL watchdog: run hung, got timeout exp completion");
    finish();
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(posedge clk); #1;
    pushExp("R1 reset state");

    // step before any load is ignored
    doStep(1'b0, "R2 step without key");
    doStep(1'b1, "R2 step without key");

    // inner binary count and hi->mid carry
    doLoad(2'd0, 2'd0, 6'h30, 1'b0, 1'b0, "R1 load capture");
    for (int i = 0; i < 3; i++) doStep(1'b0, "R2 inner count");
    doStep(1'b0, "R3 hi wrap into mid");

    // byte-reversed carries in the low word
    doLoad(2'd3, 2'd3, 6'h30, 1'b0, 1'b0, "R1 load");
    doStep(1'b0, "R4 R5 carry fast lane to middle lane");
    doLoad(2'd3, 2'd3, 6'h3C, 1'b0, 1'b0, "R1 load");
    doStep(1'b0, "R4 R5 carry ripple to bottom lane");
    doLoad(2'd3, 2'd3, 6'h0F, 1'b0, 1'b0, "R1 load");
    doStep(1'b0, "R4 R5 fast lane only");

    // full compatible sweep with modeSel toggling (R9), groups and exhaustion
    doLoad(2'd0, 2'd0, 6'h00, 1'b0, 1'b0, "R1 load compat sweep");
    for (int i = 0; i < 1030; i++)
      doStep(((i / 37) % 2) == 1, "R5 R7 R8 R9 compat sweep");

    // restart after exhaustion, partition boundary
    doLoad(2'd3, 2'd3, 6'h0D, 1'b1, 1'b0, "R1 R8 reload after exhaustion");
    doStep(1'b0, "R4 R6 partition field carry");

    // full partition sweep with tag 2
    doLoad(2'd0, 2'd0, 6'h02, 1'b1, 1'b0, "R1 load partition sweep");
    for (int i = 0; i < 260; i++)
      doStep(((i / 23) % 2) == 0, "R6 R7 R8 R9 partition sweep");

    // load wins over a simultaneous step
    doLoad(2'd1, 2'd2, 6'h15, 1'b0, 1'b1, "R1 load beats step");
    doStep(1'b1, "R2 R9 step after load");

    repeat (3) @(negedge clk);
    finish();
  end

endmodule